// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Nine-Bit Byte Pairing

This block turns a stream of bytes from a transmit queue into asynchronous serial frames on a single output line. The queue interface is a plain valid/ready handshake, and the block asserts ready only while no frame is on the line. That way a new character is pulled only after the previous one has fully left. A baud-tick input, high for one clock per bit period, sets the pace of every bit on the line. The baud generator, the queue storage and flow control sit outside the block.

Three word sizes are supported. In the seven-bit and eight-bit sizes, one queued byte makes one frame, and a parity bit can follow the data. The parity kind can be odd, even, forced one or forced zero. In the nine-bit size, two queued bytes make one frame: the first byte gives the low eight data bits, and bit 0 of the second byte gives the ninth. Parity is always off in this size. One or two stop bits close each frame. Configuration is taken at the moment a character is loaded, so changing it during a frame does not affect that frame.

Top module: `uart_ninebit_tx`

## Requirements
- R1: Out of reset, `tx_line` is 1, `tx_busy` is 0 and `fifo_ready` is 1. Whenever no frame is in progress, the line stays at 1.
- R2: `fifo_ready` is 0 for every cycle in which `tx_busy` is 1, so no byte is taken while a frame is on the line.
- R3: A frame begins with a start bit at 0 on the first baud tick after the load. The data bits follow, least significant first, and each bit lasts exactly one tick period. `tx_line` changes only on a clock edge where `baud_tick` is 1.
- R4: When `cfg_width` is 2'b00, seven data bits are sent: bits 6..0 of the byte. Bit 7 of the byte has no effect on the line.
- R5: When `cfg_width` is 2'b01 or 2'b11, eight data bits are sent: bits 7..0 of the byte.
- R6: When `cfg_par_en` is 1 and the size is not nine-bit, one parity bit follows the data. `cfg_par_kind` selects the kind: 2'b00 makes the count of ones in the data plus parity odd, 2'b01 makes it even, 2'b10 sends 1 and 2'b11 sends 0. Only the active data bits are counted.
- R7: When `cfg_width` is 2'b10, each frame sends nine data bits. Bits 7..0 come from the first of two consecutive queued bytes, and bit 8 comes from bit 0 of the second byte. Bits 7..1 of the second byte are ignored. No parity bit is sent in this size, whatever the value of `cfg_par_en`.
- R8: In nine-bit size, accepting only the first byte of a pair starts no frame. `tx_busy` stays 0, `tx_line` stays 1, and `fifo_ready` stays 1 until the second byte is accepted.
- R9: Stop bits at 1 close each frame: one stop bit when `cfg_two_stop` is 0, two when it is 1.
- R10: `tx_busy` rises in the cycle after the handshake that completes a character. It stays 1 through the last stop bit and falls on the baud tick that ends that stop bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick | input | 1 | One-cycle strobe that ends each bit period |
| cfg_width | input | 2 | Word size: 00 seven, 01/11 eight, 10 nine (paired bytes) |
| cfg_par_en | input | 1 | Parity bit enable (ignored in nine-bit size) |
| cfg_par_kind | input | 2 | 00 odd, 01 even, 10 forced one, 11 forced zero |
| cfg_two_stop | input | 1 | 1 selects two stop bits |
| fifo_valid | input | 1 | Queue has a byte |
| fifo_data | input | 8 | Byte offered by the queue |
| fifo_ready | output | 1 | Block takes the offered byte at this edge |
| tx_line | output | 1 | Serial output, idles high |
| tx_busy | output | 1 | A frame is in progress |

## Verification
The assertions check several behaviours on every cycle: the idle line level, that ready is held off while a frame is active, that the line moves only on tick edges, and that busy rises only after a handshake and falls only on a tick. The order of the data bits, the parity values, the number of stop bits, the masking of the unused bit in seven-bit size, and the assembly of the nine-bit word from a byte pair all depend on the content of a whole frame. Only the bench can show these, by decoding each frame and comparing it with its expected word. The same holds for the held half-pair that must not start a frame.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

  typedef enum logic [2:0] {
    SER_IDLE  = 3'd0,
    SER_ARM   = 3'd1,
    SER_START = 3'd2,
    SER_DATA  = 3'd3,
    SER_PAR   = 3'd4,
    SER_STOP  = 3'd5
  } ser_state_e;

  localparam logic [1:0] WIDTH_SEVEN = 2'b00;
  localparam logic [1:0] WIDTH_NINE  = 2'b10;

  localparam logic [1:0] PAR_ODD   = 2'b00;
  localparam logic [1:0] PAR_EVEN  = 2'b01;
  localparam logic [1:0] PAR_MARK  = 2'b10;
  localparam logic [1:0] PAR_SPACE = 2'b11;

endpackage

// File: rtl/uart_tx_parity.sv
module uart_tx_parity #(
  parameter int BYTE_W = 8,
  localparam int WORD_W = BYTE_W + 1
) (
  input  logic [WORD_W-1:0] word,
  input  logic [1:0]        width,
  input  logic [1:0]        kind,
  output logic              par_bit
);
  import uart_tx_pkg::*;

  logic [WORD_W-1:0] mask;
  logic              ones_odd;

  // Only the bits that go on the line take part in the parity.
  always_comb begin
    if (width == WIDTH_SEVEN)     mask = WORD_W'({(BYTE_W-1){1'b1}});
    else if (width == WIDTH_NINE) mask = {WORD_W{1'b1}};
    else                          mask = WORD_W'({BYTE_W{1'b1}});
  end

  assign ones_odd = ^(word & mask);

  always_comb begin
    case (kind)
      PAR_ODD:  par_bit = ~ones_odd;
      PAR_EVEN: par_bit = ones_odd;
      PAR_MARK: par_bit = 1'b1;
      default:  par_bit = 1'b0;
    endcase
  end

endmodule

// File: rtl/uart_tx_pairer.sv
module uart_tx_pairer #(
  parameter int BYTE_W = 8,
  localparam int WORD_W = BYTE_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              nine_mode,
  input  logic              ser_idle,
  input  logic              fifo_valid,
  input  logic [BYTE_W-1:0] fifo_data,
  output logic              fifo_ready,
  output logic              load,
  output logic [WORD_W-1:0] load_word
);

  logic              half_q, half_d;
  logic [BYTE_W-1:0] low_q, low_d;
  logic              take;

  // Bytes are taken only while the shifter has nothing on the line.
  assign fifo_ready = ser_idle;
  assign take       = fifo_valid & fifo_ready;
  assign load       = take & (~nine_mode | half_q);
  assign load_word  = nine_mode ? {fifo_data[0], low_q} : {1'b0, fifo_data};

  always_comb begin
    half_d = half_q;
    low_d  = low_q;
    if (!nine_mode) begin
      half_d = 1'b0;
    end else if (take) begin
      half_d = ~half_q;
      if (!half_q) low_d = fifo_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_q <= 1'b0;
      low_q  <= '0;
    end else begin
      half_q <= half_d;
      low_q  <= low_d;
    end
  end

endmodule

// File: rtl/uart_tx_serializer.sv
module uart_tx_serializer #(
  parameter int BYTE_W = 8,
  localparam int WORD_W = BYTE_W + 1,
  localparam int CNT_W  = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic              load,
  input  logic [WORD_W-1:0] load_word,
  input  logic [1:0]        cfg_width,
  input  logic              cfg_par_en,
  input  logic [1:0]        cfg_par_kind,
  input  logic              cfg_two_stop,
  output logic              idle,
  output logic              tx_line
);
  import uart_tx_pkg::*;

  localparam logic [CNT_W-1:0] LAST_SEVEN = CNT_W'(BYTE_W - 2);
  localparam logic [CNT_W-1:0] LAST_EIGHT = CNT_W'(BYTE_W - 1);
  localparam logic [CNT_W-1:0] LAST_NINE  = CNT_W'(BYTE_W);

  ser_state_e        state_q, state_d;
  logic [WORD_W-1:0] shreg_q, shreg_d;
  logic [CNT_W-1:0]  left_q, left_d;
  logic              par_en_q, par_en_d;
  logic              par_bit_q, par_bit_d;
  logic              two_q, two_d;
  logic              extra_q, extra_d;
  logic              tx_q, tx_d;
  logic              par_calc;
  logic [CNT_W-1:0]  last_idx;

  uart_tx_parity #(.BYTE_W(BYTE_W)) u_parity (
    .word    (load_word),
    .width   (cfg_width),
    .kind    (cfg_par_kind),
    .par_bit (par_calc)
  );

  always_comb begin
    if (cfg_width == WIDTH_SEVEN)     last_idx = LAST_SEVEN;
    else if (cfg_width == WIDTH_NINE) last_idx = LAST_NINE;
    else                              last_idx = LAST_EIGHT;
  end

  always_comb begin
    state_d   = state_q;
    shreg_d   = shreg_q;
    left_d    = left_q;
    par_en_d  = par_en_q;
    par_bit_d = par_bit_q;
    two_d     = two_q;
    extra_d   = extra_q;
    tx_d      = tx_q;
    case (state_q)
      SER_IDLE: begin
        tx_d = 1'b1;
        if (load) begin
          shreg_d   = load_word;
          left_d    = last_idx;
          par_en_d  = cfg_par_en & (cfg_width != WIDTH_NINE);
          par_bit_d = par_calc;
          two_d     = cfg_two_stop;
          state_d   = SER_ARM;
        end
      end
      SER_ARM: begin
        if (baud_tick) begin
          tx_d    = 1'b0;
          state_d = SER_START;
        end
      end
      SER_START: begin
        if (baud_tick) begin
          tx_d    = shreg_q[0];
          state_d = SER_DATA;
        end
      end
      SER_DATA: begin
        if (baud_tick) begin
          if (left_q == '0) begin
            if (par_en_q) begin
              tx_d    = par_bit_q;
              state_d = SER_PAR;
            end else begin
              tx_d    = 1'b1;
              extra_d = two_q;
              state_d = SER_STOP;
            end
          end else begin
            shreg_d = shreg_q >> 1;
            tx_d    = shreg_q[1];
            left_d  = left_q - 1'b1;
          end
        end
      end
      SER_PAR: begin
        if (baud_tick) begin
          tx_d    = 1'b1;
          extra_d = two_q;
          state_d = SER_STOP;
        end
      end
      SER_STOP: begin
        if (baud_tick) begin
          if (extra_q) extra_d = 1'b0;
          else         state_d = SER_IDLE;
        end
      end
      default: begin
        tx_d    = 1'b1;
        state_d = SER_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= SER_IDLE;
      shreg_q   <= '0;
      left_q    <= '0;
      par_en_q  <= 1'b0;
      par_bit_q <= 1'b0;
      two_q     <= 1'b0;
      extra_q   <= 1'b0;
      tx_q      <= 1'b1;
    end else begin
      state_q   <= state_d;
      shreg_q   <= shreg_d;
      left_q    <= left_d;
      par_en_q  <= par_en_d;
      par_bit_q <= par_bit_d;
      two_q     <= two_d;
      extra_q   <= extra_d;
      tx_q      <= tx_d;
    end
  end

  assign idle    = (state_q == SER_IDLE);
  assign tx_line = tx_q;

endmodule

// File: rtl/uart_ninebit_tx.sv
module uart_ninebit_tx #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic [1:0]        cfg_width,
  input  logic              cfg_par_en,
  input  logic [1:0]        cfg_par_kind,
  input  logic              cfg_two_stop,
  input  logic              fifo_valid,
  input  logic [BYTE_W-1:0] fifo_data,
  output logic              fifo_ready,
  output logic              tx_line,
  output logic              tx_busy
);
  import uart_tx_pkg::*;

  localparam int WORD_W = BYTE_W + 1;

  logic              ser_idle;
  logic              load;
  logic [WORD_W-1:0] load_word;

  uart_tx_pairer #(.BYTE_W(BYTE_W)) u_pairer (
    .clk        (clk),
    .rst_n      (rst_n),
    .nine_mode  (cfg_width == WIDTH_NINE),
    .ser_idle   (ser_idle),
    .fifo_valid (fifo_valid),
    .fifo_data  (fifo_data),
    .fifo_ready (fifo_ready),
    .load       (load),
    .load_word  (load_word)
  );

  uart_tx_serializer #(.BYTE_W(BYTE_W)) u_ser (
    .clk          (clk),
    .rst_n        (rst_n),
    .baud_tick    (baud_tick),
    .load         (load),
    .load_word    (load_word),
    .cfg_width    (cfg_width),
    .cfg_par_en   (cfg_par_en),
    .cfg_par_kind (cfg_par_kind),
    .cfg_two_stop (cfg_two_stop),
    .idle         (ser_idle),
    .tx_line      (tx_line)
  );

  assign tx_busy = ~ser_idle;

endmodule

// File: rtl/uart_ninebit_tx_chk.sv
module uart_ninebit_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic baud_tick,
  input logic fifo_valid,
  input logic fifo_ready,
  input logic tx_line,
  input logic tx_busy
);

  assert_idle_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_busy |-> tx_line);

  assert_no_take_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_busy |-> !fifo_ready);

  assert_tick_paced_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !baud_tick |=> $stable(tx_line));

  assert_start_in_frame_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_line) |-> tx_busy);

  assert_busy_after_take_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_busy) |-> $past(fifo_valid && fifo_ready));

  assert_busy_ends_on_tick_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_busy) |-> ($past(baud_tick) && tx_line));

endmodule

bind uart_ninebit_tx uart_ninebit_tx_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .baud_tick  (baud_tick),
  .fifo_valid (fifo_valid),
  .fifo_ready (fifo_ready),
  .tx_line    (tx_line),
  .tx_busy    (tx_busy)
);

// File: tb/uart_ninebit_tx_test.sv
module uart_ninebit_tx_test;

  localparam int TDIV = 5;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       baud_tick;
  logic [1:0] cfg_width;
  logic       cfg_par_en;
  logic [1:0] cfg_par_kind;
  logic       cfg_two_stop;
  logic       fifo_valid;
  logic [7:0] fifo_data;
  logic       fifo_ready;
  logic       tx_line;
  logic       tx_busy;

  always #4 clk = ~clk;

  uart_ninebit_tx uut (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick),
    .cfg_width(cfg_width), .cfg_par_en(cfg_par_en),
    .cfg_par_kind(cfg_par_kind), .cfg_two_stop(cfg_two_stop),
    .fifo_valid(fifo_valid), .fifo_data(fifo_data),
    .fifo_ready(fifo_ready), .tx_line(tx_line), .tx_busy(tx_busy)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  int q_word[$], q_nb[$], q_pe[$], q_pk[$], q_two[$];

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic bit exp_par(int w, int nb, int k);
    bit p = 0;
    for (int i = 0; i < nb; i++) p ^= w[i];
    case (k)
      0: return ~p;
      1: return p;
      2: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic int width_bits(int w);
    return (w == 0) ? 7 : (w == 2) ? 9 : 8;
  endfunction

  // Tick generator and frame decoder share one negedge process.
  int tick_cnt = 0;
  int m_phase = 0, m_cnt = 0, m_word = 0;
  int c_word, c_nb, c_pe, c_pk, c_two;

  always @(negedge clk) begin
    if (rst_n && baud_tick) begin
      case (m_phase)
        0: if (!tx_line) begin
          if (q_word.size() == 0) begin
            check(0, "R3", "start bit without queued character", 0, 1);
          end else begin
            c_word = q_word.pop_front(); c_nb = q_nb.pop_front();
            c_pe = q_pe.pop_front(); c_pk = q_pk.pop_front(); c_two = q_two.pop_front();
            check(tx_busy == 1'b1, "R10", "busy during start bit", int'(tx_busy), 1);
            m_phase = 1; m_cnt = 0; m_word = 0;
          end
        end
        1: begin
          if (tx_line) m_word |= (1 << m_cnt);
          m_cnt++;
          if (m_cnt == c_nb) begin
            check(m_word == c_word, (c_nb == 7) ? "R4" : (c_nb == 9) ? "R7" : "R5",
                  "data bits LSB first (R3)", m_word, c_word);
            m_phase = c_pe ? 2 : 3;
            m_cnt = 0;
          end
        end
        2: begin
          check(tx_line == exp_par(c_word, c_nb, c_pk), "R6", "parity bit",
                int'(tx_line), int'(exp_par(c_word, c_nb, c_pk)));
          m_phase = 3;
        end
        3: begin
          check(tx_line == 1'b1, "R9", "stop bit level", int'(tx_line), 1);
          m_cnt++;
          if (m_cnt == (c_two ? 2 : 1)) m_phase = 4;
        end
        default: begin
          check(tx_line == 1'b1 && tx_busy == 1'b0, "R10", "line/busy after last stop",
                {tx_line, tx_busy}, 2);
          m_phase = 0;
        end
      endcase
    end
    if (tick_cnt == TDIV - 1) begin
      tick_cnt = 0;
      baud_tick = 1'b1;
    end else begin
      tick_cnt++;
      baud_tick = 1'b0;
    end
  end

  task automatic send_byte(logic [7:0] b);
    while (!fifo_ready) @(negedge clk);
    fifo_valid = 1'b1;
    fifo_data  = b;
    @(negedge clk);
    fifo_valid = 1'b0;
  endtask

  task automatic drain();
    while (q_word.size() != 0 || m_phase != 0 || tx_busy) @(negedge clk);
  endtask

  task automatic set_cfg(int w, int pe, int pk, int two);
    drain();
    cfg_width = 2'(w); cfg_par_en = 1'(pe); cfg_par_kind = 2'(pk); cfg_two_stop = 1'(two);
  endtask

  task automatic send_frame(int word);
    int nb = width_bits(int'(cfg_width));
    int w  = word & ((1 << nb) - 1);
    logic [31:0] r = $urandom;
    q_word.push_back(w); q_nb.push_back(nb);
    q_pe.push_back((cfg_par_en && cfg_width != 2'b10) ? 1 : 0);
    q_pk.push_back(int'(cfg_par_kind)); q_two.push_back(int'(cfg_two_stop));
    if (cfg_width == 2'b10) begin
      send_byte(w[7:0]);
      send_byte({r[6:0], w[8]});
    end else if (cfg_width == 2'b00) begin
      send_byte({r[7], w[6:0]});
    end else begin
      send_byte(w[7:0]);
    end
  endtask

  initial begin
    logic [31:0] seed;
    seed = $urandom(32'd1410);
    rst_n = 1'b0; baud_tick = 1'b0; fifo_valid = 1'b0; fifo_data = '0;
    cfg_width = 2'b01; cfg_par_en = 1'b0; cfg_par_kind = 2'b00; cfg_two_stop = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(tx_line == 1'b1, "R1", "line after reset", int'(tx_line), 1);
    check(tx_busy == 1'b0, "R1", "busy after reset", int'(tx_busy), 0);
    check(fifo_ready == 1'b1, "R1", "ready after reset", int'(fifo_ready), 1);

    // R5 eight bits, no parity
    set_cfg(1, 0, 0, 0); send_frame('hA5); send_frame('h3C);
    @(negedge clk);
    check(tx_busy && !fifo_ready, "R2", "ready held off in frame", int'(fifo_ready), 0);
    // R4 seven bits, even parity, bit 7 ignored
    set_cfg(0, 1, 1, 0); send_frame('hFF); send_frame('h80);
    // R9 two stop bits, odd parity
    set_cfg(1, 1, 0, 1); send_frame('h00); send_frame('h01);
    // R6 mark and space
    set_cfg(3, 1, 2, 0); send_frame('h5A);
    set_cfg(1, 1, 3, 1); send_frame('hC3);
    // R7 nine bits, parity request ignored
    set_cfg(2, 1, 0, 0); send_frame('h1FF); send_frame('h100); send_frame('h0AA);

    // R8 half pair starts nothing
    drain();
    q_word.push_back('h15A); q_nb.push_back(9); q_pe.push_back(0);
    q_pk.push_back(0); q_two.push_back(0);
    send_byte(8'h5A);
    repeat (4 * TDIV) @(negedge clk);
    check(tx_busy == 1'b0, "R8", "busy with half pair", int'(tx_busy), 0);
    check(tx_line == 1'b1, "R8", "line with half pair", int'(tx_line), 1);
    check(fifo_ready == 1'b1, "R8", "ready with half pair", int'(fifo_ready), 1);
    send_byte(8'hFF);

    // Random groups
    for (int g = 0; g < 30; g++) begin
      logic [31:0] c = $urandom;
      set_cfg(int'(c[1:0]), int'(c[2]), int'(c[4:3]), int'(c[5]));
      for (int f = 0; f < 5; f++) send_frame(int'($urandom & 32'h1FF));
    end

    drain();
    repeat (3 * TDIV) @(negedge clk);
    check(q_word.size() == 0 && tx_line == 1'b1, "R1", "all frames decoded, line idle",
          q_word.size(), 0);
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL R3 watchdog expired: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule